// File: doc/BRIEF.md
# Auxiliary-Powered Power State Tracker

This block follows the power management state of an add-in card whose logic keeps running from an auxiliary supply after the main slot supply has been switched off. It watches a flag that reports whether main power is present, the active-low bus reset, and software writes of a target state. From these it reports one of four states: fully active (D0), active but not yet configured (D0-uninitialized), software-requested low power (D3hot), and main power removed (D3cold). It also drives a flag that tells the wake logic to keep its wake context alive.

The key problem is that the bus reset line falls along with the rest of the bus when main power is removed. An auxiliary-powered card would otherwise read this as a reset and try to come up while the slot is still unpowered. Here, a low reset seen without main power never moves the state. The card leaves D3cold only on the release of reset, and only while main power is present. While the card sits in D3 with wake enabled, its wake context survives the power-down reset and stays alive until software returns the card to D0.

Both asynchronous inputs, main power and bus reset, pass through a synchronizer chain clocked by the auxiliary clock before any decision is made. Software writes are taken as synchronous to that clock.

Top module: `aux_pm_tracker`

## Requirements
- R1: After the auxiliary reset, the block reports D3cold: `pm_state` = 2'b11, `pm_cold` = 1, `pm_uninit` = 0 and `wake_hold` = 0.
- R2: `pm_state` is 2'b00 in D0 and in D0-uninitialized, and 2'b11 in D3hot and in D3cold. `pm_cold` is 1 only in D3cold. `pm_uninit` is 1 only in D0-uninitialized.
- R3: When the synchronized main-power flag is low, the block moves to D3cold from any state.
- R4: Without main power, bus reset going low or coming back high leaves the state unchanged. Software writes in D3cold have no effect, and the block stays in D3cold while main power returns with reset still low.
- R5: A rising edge of the synchronized bus reset while main power is present moves the block to D0-uninitialized from any state, including the first power-up. While reset is held low with main power present, the state does not change.
- R6: Software writes use `cfg_tgt_d3` = 0 for D0 and 1 for D3hot. With reset high and main power present, the following writes take effect:
  - writing D0 in D0-uninitialized moves the block to D0;
  - writing D3hot in D0 moves it to D3hot;
  - writing D0 in D3hot moves it to D0-uninitialized.
  Every other write leaves the state unchanged.
- R7: In D3hot, `wake_hold` follows `pme_en` one cycle later. In D3cold and D0-uninitialized, `wake_hold` keeps its value. On entry to D0, `wake_hold` is cleared.
- R8: With two synchronizer stages, a change of `main_pwr_ok` or `bus_rst_n` sampled at clock edge n shows on the outputs after edge n+2. A software write sampled at edge n shows after edge n.

Both asynchronous inputs are filtered by a SYNC_STAGES-deep flop chain before the state machine acts on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_aux | input | 1 | Auxiliary-supply clock |
| aux_rst_n | input | 1 | Active-low reset of the auxiliary domain |
| main_pwr_ok | input | 1 | High while the main slot supply is present (asynchronous) |
| bus_rst_n | input | 1 | Active-low bus reset (asynchronous) |
| cfg_wr | input | 1 | One-cycle software write strobe for the target state |
| cfg_tgt_d3 | input | 1 | Written target: 0 = D0, 1 = D3hot |
| pme_en | input | 1 | Wake enable from configuration |
| pm_state | output | 2 | State encoding: 2'b00 = D0, 2'b11 = D3 |
| pm_cold | output | 1 | Qualifies D3 as D3cold |
| pm_uninit | output | 1 | Qualifies D0 as D0-uninitialized |
| wake_hold | output | 1 | Keep the wake context alive |

## Verification
The checker's timing properties assume that both asynchronous inputs stay at each level long enough for the synchronizer chain to carry it. The stimulus therefore holds every power and reset level for several clock cycles and never pulses either input for a single cycle. The properties also assume that `cfg_wr` is synchronous to the auxiliary clock and lasts one cycle. The bench drives it exactly that way, on the falling clock edge. The sweep covers both wake-enable settings and both orders in which reset and main power can fall, and it toggles `pme_en` while the card is unpowered.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [1:0] {
        ST_D0  = 2'd0,
        ST_D0U = 2'd1,
        ST_D3H = 2'd2,
        ST_D3C = 2'd3
    } pm_state_e;

    localparam logic [1:0] PSTATE_D0 = 2'b00;
    localparam logic [1:0] PSTATE_D3 = 2'b11;
    localparam logic       TGT_D0    = 1'b0;
    localparam logic       TGT_D3HOT = 1'b1;

    typedef struct packed {
        pm_state_e st;
        logic      wake;
    } trk_regs_t;

    typedef struct packed {
        logic [1:0] pstate;
        logic       cold;
        logic       uninit;
    } pm_view_t;

    function automatic pm_view_t view_of(pm_state_e s);
        pm_view_t v;
        v.pstate = PSTATE_D0;
        v.cold   = 1'b0;
        v.uninit = 1'b0;
        case (s)
            ST_D0:  v.pstate = PSTATE_D0;
            ST_D0U: begin
                v.pstate = PSTATE_D0;
                v.uninit = 1'b1;
            end
            ST_D3H: v.pstate = PSTATE_D3;
            ST_D3C: begin
                v.pstate = PSTATE_D3;
                v.cold   = 1'b1;
            end
            default: v.pstate = PSTATE_D0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pmt_sync.sv
module pmt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pmt_rise.sv
module pmt_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_d;
    logic prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/pmt_fsm.sv
module pmt_fsm
    import pmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       brst_lvl,
    input  logic       brst_rise,
    input  logic       wr,
    input  logic       tgt_d3,
    input  logic       pme_en,
    output logic [1:0] pstate,
    output logic       cold,
    output logic       uninit,
    output logic       wake
);
    trk_regs_t regs_d;
    trk_regs_t regs_q;
    pm_view_t  view;

    always_comb begin
        regs_d = regs_q;
        // Priority: supply loss, then reset release, then reset hold, then writes.
        if (!pwr_ok) begin
            regs_d.st = ST_D3C;
        end else if (brst_rise) begin
            regs_d.st = ST_D0U;
        end else if (!brst_lvl) begin
            regs_d.st = regs_q.st;
        end else if (wr) begin
            case (regs_q.st)
                ST_D0U:  if (tgt_d3 == TGT_D0)    regs_d.st = ST_D0;
                ST_D0:   if (tgt_d3 == TGT_D3HOT) regs_d.st = ST_D3H;
                ST_D3H:  if (tgt_d3 == TGT_D0)    regs_d.st = ST_D0U;
                default: regs_d.st = regs_q.st;
            endcase
        end

        case (regs_d.st)
            ST_D3H:  regs_d.wake = pme_en;
            ST_D0:   regs_d.wake = 1'b0;
            default: regs_d.wake = regs_q.wake;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st   <= ST_D3C;
            regs_q.wake <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb view = view_of(regs_q.st);

    assign pstate = view.pstate;
    assign cold   = view.cold;
    assign uninit = view.uninit;
    assign wake   = regs_q.wake;
endmodule

// File: rtl/aux_pm_tracker.sv
module aux_pm_tracker #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_aux,
    input  logic       aux_rst_n,
    input  logic       main_pwr_ok,
    input  logic       bus_rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_tgt_d3,
    input  logic       pme_en,
    output logic [1:0] pm_state,
    output logic       pm_cold,
    output logic       pm_uninit,
    output logic       wake_hold
);
    localparam int NUM_ASYNC = 2;

    logic [NUM_ASYNC-1:0] async_in;
    logic [NUM_ASYNC-1:0] sync_out;
    logic                 brst_rise;

    assign async_in = {bus_rst_n, main_pwr_ok};

    // Both asynchronous inputs reset to 0: power absent, bus reset asserted.
    generate
        for (genvar i = 0; i < NUM_ASYNC; i++) begin : g_sync
            pmt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) sync_i (
                .clk   (clk_aux),
                .rst_n (aux_rst_n),
                .d     (async_in[i]),
                .q     (sync_out[i])
            );
        end
    endgenerate

    pmt_rise rise_i (
        .clk   (clk_aux),
        .rst_n (aux_rst_n),
        .lvl   (sync_out[1]),
        .rise  (brst_rise)
    );

    pmt_fsm fsm_i (
        .clk       (clk_aux),
        .rst_n     (aux_rst_n),
        .pwr_ok    (sync_out[0]),
        .brst_lvl  (sync_out[1]),
        .brst_rise (brst_rise),
        .wr        (cfg_wr),
        .tgt_d3    (cfg_tgt_d3),
        .pme_en    (pme_en),
        .pstate    (pm_state),
        .cold      (pm_cold),
        .uninit    (pm_uninit),
        .wake      (wake_hold)
    );
endmodule

// File: rtl/aux_pm_tracker_chk.sv
module aux_pm_tracker_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk_aux,
    input logic       aux_rst_n,
    input logic       main_pwr_ok,
    input logic       bus_rst_n,
    input logic       cfg_wr,
    input logic       cfg_tgt_d3,
    input logic [1:0] pm_state,
    input logic       pm_cold,
    input logic       pm_uninit,
    input logic       wake_hold
);
    localparam int S = SYNC_STAGES;

    logic [S+1:0] pwr_hist;
    logic [S+1:0] rst_hist;

    always_ff @(posedge clk_aux or negedge aux_rst_n) begin
        if (!aux_rst_n) begin
            pwr_hist <= '0;
            rst_hist <= '0;
        end else begin
            pwr_hist <= {pwr_hist[S:0], main_pwr_ok};
            rst_hist <= {rst_hist[S:0], bus_rst_n};
        end
    end

    logic release_seen;
    assign release_seen = pwr_hist[S] && rst_hist[S] && !rst_hist[S+1];

    // R2
    a_r2_flags_exclusive: assert property (@(posedge clk_aux) disable iff (!aux_rst_n)
        !(pm_cold && pm_uninit));
    // R2
    a_r2_encoding: assert property (@(posedge clk_aux) disable iff (!aux_rst_n)
        (pm_state == 2'b00 || pm_state == 2'b11) &&
        (!pm_cold || pm_state == 2'b11) && (!pm_uninit || pm_state == 2'b00));
    // R3
    a_r3_cold_entry: assert property (@(posedge clk_aux) disable iff (!aux_rst_n)
        $rose(pm_cold) |-> !pwr_hist[S]);
    // R4 and R5
    a_r4_cold_exit: assert property (@(posedge clk_aux) disable iff (!aux_rst_n)
        $fell(pm_cold) |-> release_seen);
    // R5 and R6
    a_r5_uninit_entry: assert property (@(posedge clk_aux) disable iff (!aux_rst_n)
        $rose(pm_uninit) |-> release_seen ||
        ($past(cfg_wr) && !$past(cfg_tgt_d3) && $past(pm_state) == 2'b11 && !$past(pm_cold)));
    // R6
    a_r6_d0_entry: assert property (@(posedge clk_aux) disable iff (!aux_rst_n)
        ($fell(pm_uninit) && !pm_cold) |-> ($past(cfg_wr) && !$past(cfg_tgt_d3)));
    // R7
    a_r7_wake_clear_d0: assert property (@(posedge clk_aux) disable iff (!aux_rst_n)
        (pm_state == 2'b00 && !pm_uninit) |-> !wake_hold);
    // R7
    a_r7_wake_held_cold: assert property (@(posedge clk_aux) disable iff (!aux_rst_n)
        (pm_cold && $past(pm_cold)) |-> $stable(wake_hold));
endmodule

bind aux_pm_tracker aux_pm_tracker_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
    .clk_aux     (clk_aux),
    .aux_rst_n   (aux_rst_n),
    .main_pwr_ok (main_pwr_ok),
    .bus_rst_n   (bus_rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_tgt_d3  (cfg_tgt_d3),
    .pm_state    (pm_state),
    .pm_cold     (pm_cold),
    .pm_uninit   (pm_uninit),
    .wake_hold   (wake_hold)
);

// File: tb/aux_pm_tracker_tb_top.sv
`timescale 1ns/1ps
module aux_pm_tracker_tb_top;
    localparam int SETTLE = 5;
    localparam int S_D0 = 0, S_D0U = 1, S_D3H = 2, S_D3C = 3;

    logic       clk_aux = 1'b0;
    logic       aux_rst_n;
    logic       main_pwr_ok;
    logic       bus_rst_n;
    logic       cfg_wr;
    logic       cfg_tgt_d3;
    logic       pme_en;
    logic [1:0] pm_state;
    logic       pm_cold;
    logic       pm_uninit;
    logic       wake_hold;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk_aux = ~clk_aux;

    aux_pm_tracker #(.SYNC_STAGES(2)) dut_i (
        .clk_aux     (clk_aux),
        .aux_rst_n   (aux_rst_n),
        .main_pwr_ok (main_pwr_ok),
        .bus_rst_n   (bus_rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_tgt_d3  (cfg_tgt_d3),
        .pme_en      (pme_en),
        .pm_state    (pm_state),
        .pm_cold     (pm_cold),
        .pm_uninit   (pm_uninit),
        .wake_hold   (wake_hold)
    );

    // Expected {pm_state, pm_cold, pm_uninit, wake_hold} from state code and wake bit.
    function automatic logic [4:0] expect_of(int st, logic wk);
        logic [1:0] ps;
        ps = (st >= S_D3H) ? 2'b11 : 2'b00;
        return {ps, (st == S_D3C), (st == S_D0U), wk};
    endfunction

    task automatic check(string req, int st, logic wk);
        logic [4:0] act;
        logic [4:0] exp;
        act = {pm_state, pm_cold, pm_uninit, wake_hold};
        exp = expect_of(st, wk);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {state,cold,uninit,wake} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk_aux);
        @(negedge clk_aux);
    endtask

    task automatic sw_write(logic to_d3);
        cfg_tgt_d3 = to_d3;
        cfg_wr     = 1'b1;
        @(posedge clk_aux);
        @(negedge clk_aux);
        cfg_wr     = 1'b0;
        @(posedge clk_aux);
        @(negedge clk_aux);
    endtask

    initial begin
        aux_rst_n   = 1'b0;
        main_pwr_ok = 1'b0;
        bus_rst_n   = 1'b0;
        cfg_wr      = 1'b0;
        cfg_tgt_d3  = 1'b0;
        pme_en      = 1'b0;
        repeat (4) @(posedge clk_aux);
        @(negedge clk_aux);
        aux_rst_n = 1'b1;
        @(negedge clk_aux);
        check("R1 reset state", S_D3C, 1'b0);

        // R4: reset toggling with no main power is ignored
        bus_rst_n = 1'b1; settle(); check("R4 release without power", S_D3C, 1'b0);
        bus_rst_n = 1'b0; settle(); check("R4 assert without power", S_D3C, 1'b0);
        main_pwr_ok = 1'b1; settle(); check("R4 power back, reset low", S_D3C, 1'b0);
        sw_write(1'b0); check("R4 write D0 in D3cold", S_D3C, 1'b0);
        sw_write(1'b1); check("R4 write D3hot in D3cold", S_D3C, 1'b0);

        // R8 + R5: cold start release latency
        bus_rst_n = 1'b1;
        @(posedge clk_aux); @(posedge clk_aux); @(negedge clk_aux);
        check("R8 no change before sync delay", S_D3C, 1'b0);
        @(posedge clk_aux); @(negedge clk_aux);
        check("R5 cold start to D0-uninit", S_D0U, 1'b0);

        sw_write(1'b1); check("R6 D3hot write in D0-uninit ignored", S_D0U, 1'b0);
        sw_write(1'b0); check("R6 D0 write to D0", S_D0, 1'b0);
        sw_write(1'b0); check("R6 D0 write in D0 ignored", S_D0, 1'b0);

        // R5: reset with power present, hold then release
        bus_rst_n = 1'b0; settle(); check("R5 hold while reset low", S_D0, 1'b0);
        sw_write(1'b1); check("R5 write ignored while reset low", S_D0, 1'b0);
        bus_rst_n = 1'b1; settle(); check("R5 release to D0-uninit", S_D0U, 1'b0);
        sw_write(1'b0); check("R6 D0 write to D0", S_D0, 1'b0);

        // Sweep: wake enable x order of reset and power loss
        for (int pm = 0; pm < 2; pm++) begin
            for (int ord = 0; ord < 2; ord++) begin
                logic w;
                w = logic'(pm);
                pme_en = w;
                sw_write(1'b1);
                @(negedge clk_aux);
                check("R6 D0 write D3hot", S_D3H, w);
                pme_en = ~w; @(negedge clk_aux); @(negedge clk_aux);
                check("R7 wake follows enable in D3hot", S_D3H, ~w);
                pme_en = w; @(negedge clk_aux); @(negedge clk_aux);
                check("R7 wake follows enable in D3hot", S_D3H, w);
                if (ord == 0) begin
                    bus_rst_n = 1'b0; settle(); check("R5 reset low in D3hot holds", S_D3H, w);
                    main_pwr_ok = 1'b0; settle(); check("R3 power loss to D3cold", S_D3C, w);
                end else begin
                    main_pwr_ok = 1'b0; settle(); check("R3 power loss to D3cold", S_D3C, w);
                    bus_rst_n = 1'b0; settle(); check("R4 reset low without power", S_D3C, w);
                end
                pme_en = ~w; settle(); check("R7 wake held in D3cold", S_D3C, w);
                pme_en = w;
                main_pwr_ok = 1'b1; settle(); check("R4 power back, reset low", S_D3C, w);
                bus_rst_n = 1'b1; settle(); check("R5 release to D0-uninit", S_D0U, w);
                pme_en = ~w; settle(); check("R7 wake held in D0-uninit", S_D0U, w);
                pme_en = w;
                sw_write(1'b0); check("R7 wake cleared in D0", S_D0, 1'b0);
            end
        end

        // R6: D3hot write D0 goes to D0-uninit
        pme_en = 1'b1;
        sw_write(1'b1); @(negedge clk_aux); check("R6 D3hot entry", S_D3H, 1'b1);
        sw_write(1'b1); check("R6 D3hot write in D3hot ignored", S_D3H, 1'b1);
        sw_write(1'b0); check("R6 D3hot write D0 to D0-uninit", S_D0U, 1'b1);
        sw_write(1'b0); check("R7 wake cleared in D0", S_D0, 1'b0);

        // R8 + R3: power loss latency from D0
        main_pwr_ok = 1'b0;
        @(posedge clk_aux); @(posedge clk_aux); @(negedge clk_aux);
        check("R8 no change before sync delay", S_D0, 1'b0);
        @(posedge clk_aux); @(negedge clk_aux);
        check("R3 power loss from D0", S_D3C, 1'b0);
        main_pwr_ok = 1'b1; settle(); check("R4 power back, no reset edge", S_D3C, 1'b0);
        bus_rst_n = 1'b0; settle(); check("R5 reset low holds D3cold", S_D3C, 1'b0);
        bus_rst_n = 1'b1; settle(); check("R5 release to D0-uninit", S_D0U, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule